// File: doc/BRIEF.md
# Byte-wide programmable ROM with mode decoding

This block is a clock-synchronous model of a byte-wide, electrically programmable read-only memory. A word is `DATA_W` bits wide. The address is `ADDR_W` bits wide; the full-size part uses 15 bits (32,768 words). The default is 11 bits, which keeps elaboration small. Three control inputs select the operating mode: an active-low select, an active-high select and an active-low chip enable. Two digital flags stand in for high-voltage pin conditions. One flag marks programming voltage on the active-low select. The other marks identifier voltage on address bit 9.

The modes are read, output disable, standby, program, program verify, program inhibit and signature. In programming, the active-high select acts as the write strobe (low means write) and the chip enable acts as the verify strobe (low means verify). A write can only clear bits. A bulk-erase input returns every word to the blank value 0xFF.

The data bus is split into a write-data input and a read-data output with an output-enable flag. A separate valid flag marks when the driven data may be used. Dropping chip enable outside programming puts the device into a power-down state. After power-down, data becomes valid only after a wake-up latency that is longer than the select latency.

Top module: `prom_model`

## Requirements
- R1: While reset is asserted and right after its release, `rd_oe` = 0, `rd_valid` = 0 and `rd_data` = 0.
- R2: A cycle with `bulk_erase` = 1 sets every word to 0xFF. A program request in that same cycle is dropped.
- R3: Read mode is `prog_hv`=0, `en_n`=0, `sel_lo_n`=0 and `sel_hi`=1. The word at the address sampled on a clock edge appears on `rd_data` after that edge.
- R4: With `prog_hv`=0 and `en_n`=0, three select pairs give `rd_oe`=0 after the edge: (`sel_lo_n`,`sel_hi`)=(1,1), (0,0) with `id_hv`=0, and (1,0).
- R5: `en_n`=1 with `prog_hv`=0 is standby. It gives `rd_oe`=0 after the edge and restarts the wake-up count.
- R6: Program mode is `prog_hv`=1, `sel_hi`=0 and `en_n`=1. It stores old AND `wr_data` at the address and leaves the bus floating.
- R7: Program verify is `prog_hv`=1, `sel_hi`=1 and `en_n`=0. It drives the stored word.
- R8: With `prog_hv`=1, the pairs (`sel_hi`,`en_n`)=(1,1) and (0,0) write nothing and float the bus.
- R9: Signature mode is `prog_hv`=0, `sel_lo_n`=0, `sel_hi`=0, `en_n`=0 and `id_hv`=1. It returns 0x34 when address bit 0 is 0 and 0x20 when it is 1.
- R10: After standby, `rd_valid` first rises on the `CE_LAT`-th consecutive non-standby edge (default 5). Before that a driving mode gives `rd_oe`=1 with `rd_valid`=0.
- R11: When the device is awake, entering a driving mode (read, verify or signature) raises `rd_valid` on the `CS_LAT`-th edge (default 2). Changing the address or moving between driving modes does not lower `rd_valid`.
- R12: Whenever `rd_valid` = 0, `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Data to program |
| sel_lo_n | input | 1 | Active-low select |
| sel_hi | input | 1 | Active-high select; write strobe (low) in programming |
| en_n | input | 1 | Active-low chip enable; verify strobe (low) in programming |
| prog_hv | input | 1 | Programming-voltage condition on the active-low select |
| id_hv | input | 1 | Identifier-voltage condition on address bit 9 |
| bulk_erase | input | 1 | Sets all words to 0xFF |
| rd_data | output | DATA_W | Read data, 0 when not valid |
| rd_oe | output | 1 | Bus driven (driving mode registered) |
| rd_valid | output | 1 | Driven data is valid |

## Verification
Reads are tried on blank words, on one word programmed twice with overlapping patterns (0xA5 then 0x3C, expected 0x24) and on a word programmed once. Together these separate AND-accumulation from plain overwrite and from erase. Every non-driving select pair is applied between reads, so a float in the wrong mode or a missed float shows up. Wake-up from standby and re-entry from output disable are timed separately, which separates the chip-enable latency from the select latency. Inhibit, the unlisted programming pair, erase with a program in the same cycle, and both signature addresses each leave a distinct value to read back.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_DISABLE,
        M_SIGNATURE,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT,
        M_INVALID
    } prom_mode_e;

    localparam logic [7:0] SIG_MAKER  = 8'h34;
    localparam logic [7:0] SIG_DEVICE = 8'h20;

    function automatic logic drives_bus(prom_mode_e m);
        return (m == M_READ) || (m == M_VERIFY) || (m == M_SIGNATURE);
    endfunction

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic       sel_lo_n,
    input  logic       sel_hi,
    input  logic       en_n,
    input  logic       prog_hv,
    input  logic       id_hv,
    output prom_mode_e mode
);

    always_comb begin
        if (prog_hv) begin
            // write strobe on sel_hi, verify strobe on en_n
            case ({sel_hi, en_n})
                2'b01:   mode = M_PROGRAM;
                2'b10:   mode = M_VERIFY;
                2'b11:   mode = M_INHIBIT;
                default: mode = M_INVALID;
            endcase
        end else if (en_n) begin
            mode = M_STANDBY;
        end else if (!sel_lo_n && sel_hi) begin
            mode = M_READ;
        end else if (!sel_lo_n && !sel_hi && id_hv) begin
            mode = M_SIGNATURE;
        end else if (sel_lo_n == sel_hi) begin
            mode = M_DISABLE;
        end else begin
            mode = M_INVALID;
        end
    end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Non-volatile storage: not touched by reset.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wdata;
        end
        rdata <= cells[addr];
    end

endmodule

// File: rtl/prom_wake_timer.sv
module prom_wake_timer #(
    parameter int CE_LAT = 5,
    parameter int CS_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic select,
    output logic awake,
    output logic settled
);

    localparam int CW = $clog2(CE_LAT + 1);
    localparam int SW = $clog2(CS_LAT + 1);
    localparam logic [CW-1:0] CE_MAX = CW'(CE_LAT);
    localparam logic [SW-1:0] CS_MAX = SW'(CS_LAT);

    typedef struct packed {
        logic [CW-1:0] pwr;
        logic [SW-1:0] sel;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (sleep) begin
            tmr_d.pwr = '0;
        end else if (tmr_q.pwr != CE_MAX) begin
            tmr_d.pwr = tmr_q.pwr + 1'b1;
        end
        if (!select) begin
            tmr_d.sel = '0;
        end else if (tmr_q.sel != CS_MAX) begin
            tmr_d.sel = tmr_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign awake   = (tmr_q.pwr == CE_MAX);
    assign settled = (tmr_q.sel == CS_MAX);

endmodule

// File: rtl/prom_model.sv
module prom_model
    import prom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int CE_LAT = 5,
    parameter int CS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              en_n,
    input  logic              prog_hv,
    input  logic              id_hv,
    input  logic              bulk_erase,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              rd_valid
);

    typedef struct packed {
        prom_mode_e mode;
        logic       a0;
    } ctl_t;

    prom_mode_e        mode_now;
    ctl_t              ctl_d, ctl_q;
    logic [DATA_W-1:0] cell_rd;
    logic [DATA_W-1:0] out_word;
    logic              awake;
    logic              settled;

    prom_mode_dec u_dec (
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .en_n     (en_n),
        .prog_hv  (prog_hv),
        .id_hv    (id_hv),
        .mode     (mode_now)
    );

    prom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk   (clk),
        .erase (bulk_erase),
        .wr_en (mode_now == M_PROGRAM),
        .addr  (addr),
        .wdata (wr_data),
        .rdata (cell_rd)
    );

    prom_wake_timer #(.CE_LAT(CE_LAT), .CS_LAT(CS_LAT)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (mode_now == M_STANDBY),
        .select  (drives_bus(mode_now)),
        .awake   (awake),
        .settled (settled)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = mode_now;
        ctl_d.a0   = addr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: M_STANDBY, a0: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (ctl_q.mode == M_SIGNATURE) begin
            out_word = ctl_q.a0 ? DATA_W'(SIG_DEVICE) : DATA_W'(SIG_MAKER);
        end else begin
            out_word = cell_rd;
        end
    end

    assign rd_oe    = drives_bus(ctl_q.mode);
    assign rd_valid = rd_oe && awake && settled;
    assign rd_data  = rd_valid ? out_word : '0;

endmodule

// File: rtl/prom_model_chk.sv
module prom_model_chk
    import prom_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CE_LAT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr0,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              en_n,
    input logic              prog_hv,
    input logic              id_hv,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe,
    input logic              rd_valid
);

    localparam int RW = $clog2(CE_LAT + 1);

    logic [RW-1:0] run_q;

    // consecutive edges without standby at the pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (en_n && !prog_hv) begin
            run_q <= '0;
        end else if (run_q != RW'(CE_LAT)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R10
    wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (run_q == RW'(CE_LAT)));

    // R12
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R11
    valid_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_oe);

    // R5
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !prog_hv) |=> !rd_oe);

    // R6
    program_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && !sel_hi && en_n) |=> !rd_oe);

    // R8
    inhibit_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && sel_hi && en_n) |=> !rd_oe);

    // R9
    signature_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_hv && !en_n && !sel_lo_n && !sel_hi && id_hv) |=>
        (!rd_valid || rd_data == ($past(addr0) ? DATA_W'(SIG_DEVICE) : DATA_W'(SIG_MAKER))));

endmodule

bind prom_model prom_model_chk #(.DATA_W(DATA_W), .CE_LAT(CE_LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr0    (addr[0]),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .en_n     (en_n),
    .prog_hv  (prog_hv),
    .id_hv    (id_hv),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe),
    .rd_valid (rd_valid)
);

// File: tb/prom_model_bench.sv
`timescale 1ns/1ps
module prom_model_bench;

    localparam int AW     = 11;
    localparam int DW     = 8;
    localparam int CE_LAT = 5;
    localparam int CS_LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic          sel_lo_n, sel_hi, en_n, prog_hv, id_hv, bulk_erase;
    logic [DW-1:0] rd_data;
    logic          rd_oe, rd_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prom_model #(.ADDR_W(AW), .DATA_W(DW), .CE_LAT(CE_LAT), .CS_LAT(CS_LAT)) u_prom_model (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_data    (wr_data),
        .sel_lo_n   (sel_lo_n),
        .sel_hi     (sel_hi),
        .en_n       (en_n),
        .prog_hv    (prog_hv),
        .id_hv      (id_hv),
        .bulk_erase (bulk_erase),
        .rd_data    (rd_data),
        .rd_oe      (rd_oe),
        .rd_valid   (rd_valid)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(logic lo_n, logic hi, logic e_n, logic hv, logic idv);
        sel_lo_n = lo_n;
        sel_hi   = hi;
        en_n     = e_n;
        prog_hv  = hv;
        id_hv    = idv;
    endtask

    task automatic expect_out(string req, logic oe, logic vld, logic [DW-1:0] d);
        n_chk++;
        if (rd_oe !== oe || rd_valid !== vld || rd_data !== d) begin
            n_fail++;
            $display("FAIL %s: actual oe=%0b valid=%0b data=%02h expected oe=%0b valid=%0b data=%02h",
                     req, rd_oe, rd_valid, rd_data, oe, vld, d);
        end
    endtask

    task automatic t_reset();
        expect_out("R1 in reset", 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        tick(1);
        expect_out("R1 after release", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_blank_wake();
        bulk_erase = 1'b1;
        tick(1);
        bulk_erase = 1'b0;
        addr = '0;
        ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < CE_LAT; k++) begin
            tick(1);
            expect_out("R10 waking", 1'b1, 1'b0, 8'h00);
        end
        tick(1);
        expect_out("R10 awake, R2 blank word 0", 1'b1, 1'b1, 8'hFF);
        addr = '1;
        tick(1);
        expect_out("R2 blank top word, R11 no drop on address change", 1'b1, 1'b1, 8'hFF);
    endtask

    task automatic t_program();
        ctl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        addr = 11'h123;
        wr_data = 8'hA5;
        tick(1);
        expect_out("R6 program floats", 1'b0, 1'b0, 8'h00);
        wr_data = 8'h3C;
        tick(1);
        ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick(1);
        expect_out("R11 verify settling", 1'b1, 1'b0, 8'h00);
        tick(1);
        expect_out("R7 R6 verify A5&3C", 1'b1, 1'b1, 8'h24);
        ctl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        addr = 11'h055;
        wr_data = 8'hF0;
        tick(1);
        ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick(2);
        expect_out("R7 R6 verify single write", 1'b1, 1'b1, 8'hF0);
    endtask

    task automatic t_inhibit();
        addr = 11'h123;
        wr_data = 8'h00;
        ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        tick(2);
        expect_out("R8 inhibit floats", 1'b0, 1'b0, 8'h00);
        ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        tick(2);
        expect_out("R8 unlisted pair floats", 1'b0, 1'b0, 8'h00);
        ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick(2);
        expect_out("R8 word unchanged", 1'b1, 1'b1, 8'h24);
    endtask

    task automatic t_read_disable();
        addr = 11'h055;
        ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        tick(1);
        expect_out("R3 read 055", 1'b1, 1'b1, 8'hF0);
        addr = 11'h123;
        tick(1);
        expect_out("R3 read 123", 1'b1, 1'b1, 8'h24);
        ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        tick(1);
        expect_out("R4 R12 pair 1,1", 1'b0, 1'b0, 8'h00);
        ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1);
        expect_out("R4 pair 0,0", 1'b0, 1'b0, 8'h00);
        ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1);
        expect_out("R4 pair 1,0", 1'b0, 1'b0, 8'h00);
        ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        tick(1);
        expect_out("R11 select settling", 1'b1, 1'b0, 8'h00);
        tick(1);
        expect_out("R11 settled read", 1'b1, 1'b1, 8'h24);
    endtask

    task automatic t_signature();
        addr = 11'h122;
        ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        tick(1);
        tick(1);
        expect_out("R9 maker id", 1'b1, 1'b1, 8'h34);
        addr = 11'h123;
        tick(1);
        expect_out("R9 device id", 1'b1, 1'b1, 8'h20);
        id_hv = 1'b0;
        tick(1);
        expect_out("R4 no id voltage floats", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_standby();
        ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        tick(1);
        expect_out("R5 standby floats", 1'b0, 1'b0, 8'h00);
        ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        tick(CS_LAT);
        expect_out("R10 still waking past select latency", 1'b1, 1'b0, 8'h00);
        tick(CE_LAT - CS_LAT);
        expect_out("R10 valid after wake", 1'b1, 1'b1, 8'h24);
    endtask

    task automatic t_erase_priority();
        addr = 11'h010;
        wr_data = 8'h00;
        ctl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        bulk_erase = 1'b1;
        tick(1);
        bulk_erase = 1'b0;
        ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick(2);
        expect_out("R2 program dropped under erase", 1'b1, 1'b1, 8'hFF);
        addr = 11'h123;
        tick(1);
        expect_out("R2 programmed word erased", 1'b1, 1'b1, 8'hFF);
        addr = 11'h055;
        tick(1);
        expect_out("R2 second word erased", 1'b1, 1'b1, 8'hFF);
    endtask

    initial begin
        rst_n      = 1'b0;
        addr       = '0;
        wr_data    = '0;
        bulk_erase = 1'b0;
        ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        tick(3);
        t_reset();
        t_blank_wake();
        t_program();
        t_inhibit();
        t_read_disable();
        t_signature();
        t_standby();
        t_erase_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule